// File: doc/BRIEF.md
# Expanded RAM access steering decoder

This block decides where each external-data-space access of an 8-bit controller core lands. The access goes either to the on-chip expanded RAM or, through a request to the external bus controller, off chip. The core presents one access per cycle. The access takes one of two forms. The narrow form addresses memory through an 8-bit register value. The wide form uses the currently selected 16-bit data pointer. The block returns a registered set of strobes one cycle later: an on-chip enable, write strobe and address, or an external request with its high and low address bytes and read or write strobes.

The block also owns the two 16-bit data pointers and the pointer-select register. The select register holds a select bit and a general-purpose flag. The memory configuration bit that forces every access off chip lives here too. The core updates this state through a byte-wide register write port and two increment pulses. The on-chip RAM size is a parameter of 256 or 768 bytes. The high address byte for narrow external accesses comes from the port 2 latch, which the block receives as an input.

Top module: `xram_steer`

## Requirements
- R1: The on-chip range is addresses 0 up to XRAM_BYTES-1, with XRAM_BYTES either 256 or 768. A 16-bit address is on-chip only when it is below that limit and the external-only bit is 0.
- R2: With the external-only bit at 0, a wide access to an address at or above the limit raises ext_req. ext_hi carries pointer bits 15:8 and ext_lo carries pointer bits 7:0. A wide access below the limit raises xram_en with xram_addr equal to the pointer.
- R3: An on-chip access keeps ext_req, ext_rd and ext_wr low and holds ext_hi and ext_lo at 00h.
- R4: With the external-only bit at 0, a narrow access is always on-chip at the address given by acc_reg, zero-extended. page_hi has no effect. In the 768-byte variant, addresses 100h to 2FFh are therefore reachable only by a wide access.
- R5: With the external-only bit at 1, every access raises ext_req and never xram_en. A narrow access places page_hi on ext_hi and acc_reg on ext_lo. A wide access places the pointer bytes on ext_hi and ext_lo.
- R6: There are two 16-bit pointers. The select bit is bit 0 of the select register at address A2h: 0 picks pointer 0 and 1 picks pointer 1. ptr_cur shows the selected pointer.
- R7: A sel_inc pulse toggles the select bit and leaves the flag unchanged. The flag is bit 3 of the select register at A2h and is set only by a write. A register write to A2h in the same cycle takes priority over sel_inc.
- R8: After reset, both pointers are 0000h, the external-only bit is 0, and the select bit and the flag are 0.
- R9: A write to 82h loads the low byte, and a write to 83h loads the high byte, of the selected pointer only. A ptr_inc pulse adds one to the selected pointer only, wrapping from FFFFh to 0000h. A pointer load in the same cycle takes priority over ptr_inc.
- R10: Access outputs are registered. They appear in the cycle after the one in which acc_req is high and last one cycle. On an external access, ext_rd follows a read and ext_wr follows a write. wdata carries acc_wdata on a write and 00h otherwise.
- R11: The external-only bit is bit 1 of the register at 8Eh. The other bits at 8Eh, and register writes to addresses the block does not own, change nothing visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit pointer form, 0 = 8-bit register form |
| acc_reg | input | 8 | Register value for the narrow form |
| acc_wdata | input | 8 | Data to write |
| page_hi | input | 8 | Port 2 latch contents, high byte for narrow external accesses |
| ptr_inc | input | 1 | Increment the selected pointer |
| sel_inc | input | 1 | Increment (toggle) the select register |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| xram_en | output | 1 | On-chip RAM access enable |
| xram_we | output | 1 | On-chip RAM write strobe |
| xram_addr | output | $clog2(XRAM_BYTES) | On-chip RAM address |
| ext_req | output | 1 | External bus access request |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_hi | output | 8 | External address high byte |
| ext_lo | output | 8 | External address low byte |
| wdata | output | 8 | Write data for either destination |
| ptr_cur | output | 16 | Currently selected pointer |
| ptr_sel | output | 1 | Select bit |
| gp_flag | output | 1 | General-purpose flag |
| ext_mode | output | 1 | External-only bit |

## Verification
The properties assume the core raises acc_req only with stable, known form and direction bits. They also assume a register write and an increment of the same register never collide unless the priority rule is the point being tested. The directed stimulus drives every input on the falling edge and pulses each control for exactly one cycle. It keeps one operation per cycle except where a test targets a priority, so every output change traces back to a single cause. The boundary addresses 0FFh, 100h, 2FFh and 300h go through both access forms under both settings of the external-only bit. They are applied to a 768-byte and a 256-byte instance side by side.

// File: rtl/xram_steer_pkg.sv
package xram_steer_pkg;
    localparam int ADDR_W = 16;

    localparam logic [7:0] REG_PTR_LO = 8'h82;
    localparam logic [7:0] REG_PTR_HI = 8'h83;
    localparam logic [7:0] REG_MEMCFG = 8'h8E;
    localparam logic [7:0] REG_PSEL   = 8'hA2;

    localparam int MEMCFG_EXT_BIT = 1;
    localparam int PSEL_SEL_BIT   = 0;
    localparam int PSEL_FLAG_BIT  = 3;

    typedef enum logic {
        ACC_NARROW = 1'b0,
        ACC_WIDE   = 1'b1
    } acc_form_e;

    typedef struct packed {
        logic              onchip;
        logic [ADDR_W-1:0] addr;
    } route_t;
endpackage

// File: rtl/xram_steer_ctl.sv
module xram_steer_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic psel_we,
    input  logic new_ext,
    input  logic new_sel,
    input  logic new_flag,
    input  logic sel_inc,
    output logic ext_mode,
    output logic sel,
    output logic flag
);
    typedef struct packed {
        logic ext;
        logic sel;
        logic flag;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (sel_inc) begin
            ctl_d.sel = ~ctl_q.sel;
        end
        if (psel_we) begin
            ctl_d.sel  = new_sel;
            ctl_d.flag = new_flag;
        end
        if (cfg_we) begin
            ctl_d.ext = new_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ext_mode = ctl_q.ext;
    assign sel      = ctl_q.sel;
    assign flag     = ctl_q.flag;
endmodule

// File: rtl/xram_steer_ptrs.sv
module xram_steer_ptrs
    import xram_steer_pkg::*;
#(
    parameter int NUM_PTR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [7:0]        wbyte,
    input  logic              inc,
    output logic [ADDR_W-1:0] cur
);
    logic [ADDR_W-1:0] ptr_d [NUM_PTR];
    logic [ADDR_W-1:0] ptr_q [NUM_PTR];

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        logic hit;
        assign hit = (int'(sel) == g);

        always_comb begin
            ptr_d[g] = ptr_q[g];
            if (hit) begin
                if (ld_lo || ld_hi) begin
                    if (ld_lo) ptr_d[g][7:0]  = wbyte;
                    if (ld_hi) ptr_d[g][15:8] = wbyte;
                end else if (inc) begin
                    ptr_d[g] = ptr_q[g] + 16'd1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q[g] <= '0;
            end else begin
                ptr_q[g] <= ptr_d[g];
            end
        end
    end

    assign cur = ptr_q[sel];
endmodule

// File: rtl/xram_steer_route.sv
module xram_steer_route
    import xram_steer_pkg::*;
#(
    parameter int XRAM_BYTES = 768
) (
    input  acc_form_e         form,
    input  logic              ext_mode,
    input  logic [7:0]        page_hi,
    input  logic [7:0]        reg_val,
    input  logic [ADDR_W-1:0] ptr,
    output route_t            route
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(XRAM_BYTES);

    always_comb begin
        if (form == ACC_WIDE) begin
            route.addr = ptr;
        end else if (ext_mode) begin
            route.addr = {page_hi, reg_val};
        end else begin
            route.addr = {8'h00, reg_val};
        end
        route.onchip = !ext_mode && ({1'b0, route.addr} < LIMIT);
    end
endmodule

// File: rtl/xram_steer.sv
module xram_steer
    import xram_steer_pkg::*;
#(
    parameter int XRAM_BYTES = 768,
    localparam int XRAM_AW   = $clog2(XRAM_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_req,
    input  logic               acc_wr,
    input  logic               acc_wide,
    input  logic [7:0]         acc_reg,
    input  logic [7:0]         acc_wdata,
    input  logic [7:0]         page_hi,
    input  logic               ptr_inc,
    input  logic               sel_inc,
    input  logic               sfr_wr,
    input  logic [7:0]         sfr_addr,
    input  logic [7:0]         sfr_wdata,
    output logic               xram_en,
    output logic               xram_we,
    output logic [XRAM_AW-1:0] xram_addr,
    output logic               ext_req,
    output logic               ext_rd,
    output logic               ext_wr,
    output logic [7:0]         ext_hi,
    output logic [7:0]         ext_lo,
    output logic [7:0]         wdata,
    output logic [15:0]        ptr_cur,
    output logic               ptr_sel,
    output logic               gp_flag,
    output logic               ext_mode
);
    typedef struct packed {
        logic               xram_en;
        logic               xram_we;
        logic [XRAM_AW-1:0] xram_addr;
        logic               ext_req;
        logic               ext_rd;
        logic               ext_wr;
        logic [7:0]         ext_hi;
        logic [7:0]         ext_lo;
        logic [7:0]         wdata;
    } out_t;

    out_t   out_d, out_q;
    route_t route;
    logic   cfg_we, psel_we, ld_lo, ld_hi;
    logic   sel_q;
    logic [ADDR_W-1:0] ptr_q;

    assign cfg_we  = sfr_wr && (sfr_addr == REG_MEMCFG);
    assign psel_we = sfr_wr && (sfr_addr == REG_PSEL);
    assign ld_lo   = sfr_wr && (sfr_addr == REG_PTR_LO);
    assign ld_hi   = sfr_wr && (sfr_addr == REG_PTR_HI);

    xram_steer_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .psel_we  (psel_we),
        .new_ext  (sfr_wdata[MEMCFG_EXT_BIT]),
        .new_sel  (sfr_wdata[PSEL_SEL_BIT]),
        .new_flag (sfr_wdata[PSEL_FLAG_BIT]),
        .sel_inc  (sel_inc),
        .ext_mode (ext_mode),
        .sel      (sel_q),
        .flag     (gp_flag)
    );

    xram_steer_ptrs #(.NUM_PTR(2)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel_q),
        .ld_lo (ld_lo),
        .ld_hi (ld_hi),
        .wbyte (sfr_wdata),
        .inc   (ptr_inc),
        .cur   (ptr_q)
    );

    xram_steer_route #(.XRAM_BYTES(XRAM_BYTES)) u_route (
        .form     (acc_form_e'(acc_wide)),
        .ext_mode (ext_mode),
        .page_hi  (page_hi),
        .reg_val  (acc_reg),
        .ptr      (ptr_q),
        .route    (route)
    );

    always_comb begin
        out_d           = '0;
        out_d.xram_addr = route.addr[XRAM_AW-1:0];
        if (acc_req) begin
            out_d.wdata = acc_wr ? acc_wdata : 8'h00;
            if (route.onchip) begin
                out_d.xram_en = 1'b1;
                out_d.xram_we = acc_wr;
            end else begin
                out_d.ext_req = 1'b1;
                out_d.ext_rd  = !acc_wr;
                out_d.ext_wr  = acc_wr;
                out_d.ext_hi  = route.addr[15:8];
                out_d.ext_lo  = route.addr[7:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign xram_en   = out_q.xram_en;
    assign xram_we   = out_q.xram_we;
    assign xram_addr = out_q.xram_addr;
    assign ext_req   = out_q.ext_req;
    assign ext_rd    = out_q.ext_rd;
    assign ext_wr    = out_q.ext_wr;
    assign ext_hi    = out_q.ext_hi;
    assign ext_lo    = out_q.ext_lo;
    assign wdata     = out_q.wdata;
    assign ptr_cur   = ptr_q;
    assign ptr_sel   = sel_q;
endmodule

// File: rtl/xram_steer_chk.sv
module xram_steer_chk
    import xram_steer_pkg::*;
#(
    parameter int XRAM_BYTES = 768,
    localparam int XRAM_AW   = $clog2(XRAM_BYTES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_req,
    input logic               acc_wr,
    input logic               acc_wide,
    input logic [7:0]         acc_reg,
    input logic               sel_inc,
    input logic               sfr_wr,
    input logic [7:0]         sfr_addr,
    input logic               xram_en,
    input logic               xram_we,
    input logic [XRAM_AW-1:0] xram_addr,
    input logic               ext_req,
    input logic               ext_rd,
    input logic               ext_wr,
    input logic [7:0]         ext_hi,
    input logic [7:0]         ext_lo,
    input logic [15:0]        ptr_cur,
    input logic               ptr_sel,
    input logic               ext_mode
);
    localparam logic [16:0] LIMIT = 17'(XRAM_BYTES);

    p_onchip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xram_en |-> (!ext_req && !ext_rd && !ext_wr && ext_hi == 8'h00 && ext_lo == 8'h00));

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd && ext_wr) && !(xram_en && ext_req) && (xram_we -> xram_en));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> (!xram_en && !ext_req));

    p_narrow_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_wide && !ext_mode) |=>
            (xram_en && xram_addr == XRAM_AW'($past(acc_reg))));

    p_all_external_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && ext_mode) |=> (ext_req && !xram_en));

    p_wide_above_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_wide && !ext_mode && {1'b0, ptr_cur} >= LIMIT) |=>
            (ext_req && {ext_hi, ext_lo} == $past(ptr_cur)));

    p_sel_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_inc && !(sfr_wr && sfr_addr == REG_PSEL)) |=> (ptr_sel != $past(ptr_sel)));

    p_reset_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ptr_cur == 16'h0000 && !ext_mode && !ptr_sel));
endmodule

bind xram_steer xram_steer_chk #(.XRAM_BYTES(XRAM_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_req   (acc_req),
    .acc_wr    (acc_wr),
    .acc_wide  (acc_wide),
    .acc_reg   (acc_reg),
    .sel_inc   (sel_inc),
    .sfr_wr    (sfr_wr),
    .sfr_addr  (sfr_addr),
    .xram_en   (xram_en),
    .xram_we   (xram_we),
    .xram_addr (xram_addr),
    .ext_req   (ext_req),
    .ext_rd    (ext_rd),
    .ext_wr    (ext_wr),
    .ext_hi    (ext_hi),
    .ext_lo    (ext_lo),
    .ptr_cur   (ptr_cur),
    .ptr_sel   (ptr_sel),
    .ext_mode  (ext_mode)
);

// File: tb/test_xram_steer.sv
module test_xram_steer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic acc_req = 0, acc_wr = 0, acc_wide = 0;
    logic [7:0] acc_reg = 0, acc_wdata = 0, page_hi = 0;
    logic ptr_inc = 0, sel_inc = 0, sfr_wr = 0;
    logic [7:0] sfr_addr = 0, sfr_wdata = 0;

    logic a_en, a_we, a_req, a_rd, a_wr, a_sel, a_flag, a_ext;
    logic [9:0] a_xa;
    logic [7:0] a_hi, a_lo, a_wd;
    logic [15:0] a_ptr;
    logic b_en, b_we, b_req, b_rd, b_wr, b_sel, b_flag, b_ext;
    logic [7:0] b_xa;
    logic [7:0] b_hi, b_lo, b_wd;
    logic [15:0] b_ptr;

    xram_steer #(.XRAM_BYTES(768)) i_xram_steer (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr),
        .acc_wide(acc_wide), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
        .page_hi(page_hi), .ptr_inc(ptr_inc), .sel_inc(sel_inc),
        .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .xram_en(a_en), .xram_we(a_we), .xram_addr(a_xa), .ext_req(a_req),
        .ext_rd(a_rd), .ext_wr(a_wr), .ext_hi(a_hi), .ext_lo(a_lo),
        .wdata(a_wd), .ptr_cur(a_ptr), .ptr_sel(a_sel), .gp_flag(a_flag),
        .ext_mode(a_ext)
    );

    xram_steer #(.XRAM_BYTES(256)) i_xram_steer_256 (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr),
        .acc_wide(acc_wide), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
        .page_hi(page_hi), .ptr_inc(ptr_inc), .sel_inc(sel_inc),
        .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .xram_en(b_en), .xram_we(b_we), .xram_addr(b_xa), .ext_req(b_req),
        .ext_rd(b_rd), .ext_wr(b_wr), .ext_hi(b_hi), .ext_lo(b_lo),
        .wdata(b_wd), .ptr_cur(b_ptr), .ptr_sel(b_sel), .gp_flag(b_flag),
        .ext_mode(b_ext)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Bench model of the programmer-visible state, kept from the requirements.
    logic [15:0] m_ptr0 = 0, m_ptr1 = 0;
    logic m_sel = 0, m_flag = 0, m_ext = 0;

    function automatic logic [15:0] m_cur();
        return m_sel ? m_ptr1 : m_ptr0;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic sfr_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 0;
        case (a)
            8'h82: if (m_sel) m_ptr1[7:0]  = d; else m_ptr0[7:0]  = d;
            8'h83: if (m_sel) m_ptr1[15:8] = d; else m_ptr0[15:8] = d;
            8'h8E: m_ext = d[1];
            8'hA2: begin m_sel = d[0]; m_flag = d[3]; end
            default: ;
        endcase
    endtask

    task automatic load_ptr(logic [15:0] v);
        sfr_write(8'h83, v[15:8]);
        sfr_write(8'h82, v[7:0]);
    endtask

    task automatic pulse_ptr_inc();
        @(negedge clk); ptr_inc = 1;
        @(negedge clk); ptr_inc = 0;
        if (m_sel) m_ptr1 = m_ptr1 + 16'd1; else m_ptr0 = m_ptr0 + 16'd1;
    endtask

    task automatic pulse_sel_inc();
        @(negedge clk); sel_inc = 1;
        @(negedge clk); sel_inc = 0;
        m_sel = ~m_sel;
    endtask

    task automatic check_state(string req);
        check(req, "big ptr_cur", a_ptr, m_cur());
        check(req, "small ptr_cur", b_ptr, m_cur());
        check(req, "ptr_sel", {a_sel, b_sel}, {m_sel, m_sel});
        check(req, "gp_flag", {a_flag, b_flag}, {m_flag, m_flag});
        check(req, "ext_mode", {a_ext, b_ext}, {m_ext, m_ext});
    endtask

    task automatic verify_dut(string req, string tag, int size, logic wide, logic wr,
                              logic [7:0] r, logic [7:0] pg, logic [7:0] d,
                              logic en, logic we, logic [9:0] xa, logic rq, logic rd,
                              logic wrs, logic [7:0] hi, logic [7:0] lo, logic [7:0] wd);
        logic [15:0] a;
        logic on;
        a  = wide ? m_cur() : (m_ext ? {pg, r} : {8'h00, r});
        on = !m_ext && (int'(a) < size);
        check(req, {tag, " xram_en"}, en, on);
        check(req, {tag, " xram_we"}, we, on && wr);
        if (on) check(req, {tag, " xram_addr"}, xa, a[9:0]);
        check(req, {tag, " ext_req"}, rq, !on);
        check(req, {tag, " ext_rd"}, rd, !on && !wr);
        check(req, {tag, " ext_wr"}, wrs, !on && wr);
        check(req, {tag, " ext_hi"}, hi, on ? 8'h00 : a[15:8]);
        check(req, {tag, " ext_lo"}, lo, on ? 8'h00 : a[7:0]);
        check(req, {tag, " wdata"}, wd, wr ? d : 8'h00);
    endtask

    task automatic access(string req, logic wide, logic wr, logic [7:0] r,
                          logic [7:0] pg, logic [7:0] d);
        @(negedge clk);
        acc_req = 1; acc_wide = wide; acc_wr = wr; acc_reg = r; page_hi = pg; acc_wdata = d;
        @(negedge clk);
        acc_req = 0;
        verify_dut(req, "big", 768, wide, wr, r, pg, d,
                   a_en, a_we, a_xa, a_req, a_rd, a_wr, a_hi, a_lo, a_wd);
        verify_dut(req, "small", 256, wide, wr, r, pg, d,
                   b_en, b_we, {2'b00, b_xa}, b_req, b_rd, b_wr, b_hi, b_lo, b_wd);
    endtask

    task automatic t_reset();
        check_state("R8");
        check("R8", "idle outputs", {a_en, a_req, b_en, b_req}, 4'b0000);
    endtask

    task automatic t_pointers();
        sfr_write(8'hA2, 8'h00);
        load_ptr(16'h0123);
        check_state("R9");
        sfr_write(8'hA2, 8'h01);
        check_state("R6");
        load_ptr(16'h02FF);
        pulse_ptr_inc();
        check_state("R9");
        sfr_write(8'hA2, 8'h00);
        check_state("R6");
        load_ptr(16'hFFFF);
        pulse_ptr_inc();
        check("R9", "wrap ptr_cur", a_ptr, 16'h0000);
        check_state("R9");
    endtask

    task automatic t_toggle();
        sfr_write(8'hA2, 8'h08);
        pulse_sel_inc();
        check_state("R7");
        pulse_sel_inc();
        check_state("R7");
        // Register write and increment in the same cycle: the write wins.
        @(negedge clk);
        sel_inc = 1; sfr_wr = 1; sfr_addr = 8'hA2; sfr_wdata = 8'h01;
        @(negedge clk);
        sel_inc = 0; sfr_wr = 0;
        m_sel = 1'b1; m_flag = 1'b0;
        check_state("R7");
        sfr_write(8'hA2, 8'h00);
    endtask

    task automatic t_wide_map(logic ext);
        logic [15:0] bnd [4] = '{16'h00FF, 16'h0100, 16'h02FF, 16'h0300};
        sfr_write(8'h8E, ext ? 8'h02 : 8'h00);
        for (int i = 0; i < 4; i++) begin
            load_ptr(bnd[i]);
            access(ext ? "R5" : "R2", 1'b1, 1'b0, 8'h5A, 8'h77, 8'h00);
            access(ext ? "R5" : "R1", 1'b1, 1'b1, 8'h5A, 8'h77, 8'hC3);
        end
    endtask

    task automatic t_narrow_map(logic ext);
        logic [15:0] bnd [4] = '{16'h00FF, 16'h0100, 16'h02FF, 16'h0300};
        sfr_write(8'h8E, ext ? 8'h02 : 8'h00);
        load_ptr(16'h0300);
        for (int i = 0; i < 4; i++) begin
            access(ext ? "R5" : "R4", 1'b0, 1'b0, bnd[i][7:0], bnd[i][15:8], 8'h00);
            access(ext ? "R5" : "R3", 1'b0, 1'b1, bnd[i][7:0], bnd[i][15:8], 8'h3C);
        end
    endtask

    task automatic t_ignored();
        sfr_write(8'h8E, 8'hFD);
        check_state("R11");
        access("R11", 1'b0, 1'b0, 8'h10, 8'h02, 8'h00);
        load_ptr(16'h1234);
        sfr_write(8'h81, 8'hFF);
        sfr_write(8'hA0, 8'hFF);
        check_state("R11");
    endtask

    task automatic t_timing();
        sfr_write(8'h8E, 8'h00);
        load_ptr(16'h0010);
        access("R10", 1'b1, 1'b1, 8'h00, 8'h00, 8'hA5);
        @(negedge clk);
        check("R10", "one-cycle pulse", {a_en, a_we, a_req, b_en, b_we, b_req}, 6'b000000);
        check("R10", "wdata cleared", {a_wd, b_wd}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pointers();
        t_toggle();
        t_wide_map(1'b0);
        t_wide_map(1'b1);
        t_narrow_map(1'b0);
        t_narrow_map(1'b1);
        t_ignored();
        t_timing();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule